// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Rewind

This block buffers words between two unrelated clock domains. A producer writes on its own clock and a consumer reads on another. Either clock may run at any rate, including stopped. Pointers cross between the domains as Gray codes through two-stage synchronizers. Full and half-full are resolved in the write domain, and the read-side flag is resolved in the read domain.

The read timing is fixed by a select input while master reset is held. In standard timing, a word moves to the output register only when a read is requested. In fall-through timing, the oldest stored word is loaded into the output register without being asked for, and each read request moves the next word up. The read flag therefore means either "empty" or "no word presented", depending on the timing. A partial reset empties the FIFO and keeps the chosen timing.

A mark input, held high, pins the oldest word the reader has not yet consumed. While the mark is held, a low pulse on the rewind input returns the read pointer to that word, so the same span can be replayed. The writer may not overwrite pinned storage: space is freed only up to the mark, or up to the reader when no mark is held.

Top module: `dcfifo_rewind`

## Requirements
- R1: After master reset, rd_flag_o is 1, wr_flag_o is 0 and half_o is 0, in either timing.
- R2: In standard timing (fwft_sel_i = 0 at reset), a stored word does not reach rdata_o until ren_ni is low at an rclk edge. That edge loads the oldest word into rdata_o, and rd_flag_o is 1 exactly when no unread word is stored.
- R3: In fall-through timing (fwft_sel_i = 1 at reset), a word written into an empty FIFO appears on rdata_o with rd_flag_o = 0 by the third rclk edge after it is synchronized, with ren_ni high. Each rclk edge with ren_ni low consumes the presented word and presents the next one, if there is one.
- R4: Words leave in the order they were accepted, with their values intact.
- R5: wr_flag_o is 1 when 2**ADDR_W words are held. A write attempted while it is 1 is dropped and stores nothing.
- R6: A read attempted while nothing is stored changes neither rdata_o nor the read position.
- R7: half_o is 1 when at least 2**(ADDR_W-1) words are held, counting words pinned by a mark. It rises on the wclk edge that stores the word reaching that count.
- R8: The timing is taken from fwft_sel_i only while rst_ni is low. Later changes of fwft_sel_i have no effect.
- R9: A low prst_ni empties the FIFO (rd_flag_o = 1, wr_flag_o = 0, half_o = 0) and keeps the timing chosen at the last master reset.
- R10: When mark_i rises at an rclk edge, the oldest unconsumed word is pinned. While mark_i stays high, rt_ni low at an rclk edge returns reading to the pinned word. mark_i low releases the pin.
- R11: While a mark is held, reads free no storage, and the FIFO stays full until the mark is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous; timing sampled while low |
| prst_ni | input | 1 | Partial reset, active low, asynchronous; keeps the timing |
| fwft_sel_i | input | 1 | Timing select: 0 standard, 1 fall-through |
| wen_ni | input | 1 | Write request, active low |
| wdata_i | input | DATA_W | Write data |
| ren_ni | input | 1 | Read request, active low |
| rdata_o | output | DATA_W | Read data register |
| mark_i | input | 1 | Hold high to pin the oldest unconsumed word |
| rt_ni | input | 1 | Rewind to the pinned word, active low |
| rd_flag_o | output | 1 | Standard: empty. Fall-through: no word presented |
| wr_flag_o | output | 1 | Full, or not ready for input |
| half_o | output | 1 | At least half the storage held |

## Verification
Write-side results (full, half-full, dropped writes) are due on the same wclk edge that stores the word, so the bench samples them on the following falling wclk edge. A standard read is due one rclk edge after ren_ni is seen low. A fall-through head word is due two synchronizer edges plus one load edge after the write. Space released by reading or by dropping a mark reaches the writer only after the free pointer steps forward one location per rclk and crosses two wclk stages. The bench therefore waits a fixed margin of rclk periods after any cross-domain event before it samples, and it samples read-side outputs only on falling rclk edges.

// File: rtl/dcfifo_rewind_pkg.sv
package dcfifo_rewind_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} rd_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_rewind_sync.sv
module dcfifo_rewind_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dcfifo_rewind_wr.sv
module dcfifo_rewind_wr
  import dcfifo_rewind_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_ni,
  input  logic [ADDR_W:0]   free_gray_s_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wptr_o,
  output logic [ADDR_W:0]   wgray_o,
  output logic [ADDR_W:0]   wfree_o,
  output logic              full_o,
  output logic              half_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wptr_q, wgray_q, free_bin, used, wptr_nx;

  assign free_bin = PW'(gray2bin(32'(free_gray_s_i)));
  assign used     = wptr_q - free_bin;
  assign full_o   = (used == PW'(DEPTH));
  assign half_o   = (used >= PW'(DEPTH / 2));
  assign we_o     = !wen_ni && !full_o;
  assign wptr_nx  = wptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wptr_q  <= wptr_nx;
      wgray_q <= PW'(bin2gray(32'(wptr_nx)));
    end
  end

  assign waddr_o = wptr_q[ADDR_W-1:0];
  assign wptr_o  = wptr_q;
  assign wgray_o = wgray_q;
  assign wfree_o = free_bin;
endmodule

// File: rtl/dcfifo_rewind_rd.sv
module dcfifo_rewind_rd
  import dcfifo_rewind_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_mode_e          mode_i,
  input  logic              ren_ni,
  input  logic              mark_i,
  input  logic              rt_ni,
  input  logic [ADDR_W:0]   wgray_s_i,
  input  logic [DATA_W-1:0] mem_q_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_flag_o,
  output logic [ADDR_W:0]   rptr_o,
  output logic [ADDR_W:0]   rfree_o,
  output logic [ADDR_W:0]   rfree_gray_o,
  output logic [ADDR_W:0]   mark_ptr_o,
  output logic              mark_act_o
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rptr_q, free_q, free_gray_q, mark_q, wbin, base, target, free_nx;
  logic [DATA_W-1:0] data_q;
  logic valid_q, mark_act_q, empty, rd_req, rewind, load, fwft;

  assign fwft    = (mode_i == MODE_FWFT);
  assign wbin    = PW'(gray2bin(32'(wgray_s_i)));
  assign empty   = (rptr_q == wbin);
  assign rd_req  = !ren_ni;
  assign rewind  = !rt_ni && mark_act_q;
  assign load    = !rewind && !empty && (fwft ? (!valid_q || rd_req) : rd_req);
  // oldest word not yet handed to the consumer
  assign base    = rptr_q - PW'(fwft && valid_q);
  assign target  = mark_act_q ? mark_q : base;
  assign free_nx = free_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q      <= '0;
      data_q      <= '0;
      valid_q     <= 1'b0;
      mark_q      <= '0;
      mark_act_q  <= 1'b0;
      free_q      <= '0;
      free_gray_q <= '0;
    end else begin
      if (rewind)    rptr_q <= mark_q;
      else if (load) rptr_q <= rptr_q + PW'(1);

      if (load) data_q <= mem_q_i;

      if (rewind)      valid_q <= 1'b0;
      else if (load)   valid_q <= 1'b1;
      else if (rd_req) valid_q <= 1'b0;

      if (mark_i && !mark_act_q) begin
        mark_act_q <= 1'b1;
        mark_q     <= base;
      end else if (!mark_i) begin
        mark_act_q <= 1'b0;
      end

      // release one location per cycle so the Gray copy changes one bit at a time
      if (target != free_q) begin
        free_q      <= free_nx;
        free_gray_q <= PW'(bin2gray(32'(free_nx)));
      end
    end
  end

  assign raddr_o      = rptr_q[ADDR_W-1:0];
  assign rdata_o      = data_q;
  assign rd_flag_o    = fwft ? !valid_q : empty;
  assign rptr_o       = rptr_q;
  assign rfree_o      = free_q;
  assign rfree_gray_o = free_gray_q;
  assign mark_ptr_o   = mark_q;
  assign mark_act_o   = mark_act_q;
endmodule

// File: rtl/dcfifo_rewind.sv
module dcfifo_rewind
  import dcfifo_rewind_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              fwft_sel_i,
  input  logic              wen_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_ni,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              mark_i,
  input  logic              rt_ni,
  output logic              rd_flag_o,
  output logic              wr_flag_o,
  output logic              half_o
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic ptr_rst_n, mrst_act, we;
  rd_mode_e mode_q;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0] w_ptr, w_gray, w_free, w_gray_s, r_ptr, r_free, r_free_gray, r_free_gray_s, mark_ptr;
  logic mark_act;
  logic [DATA_W-1:0] mem [DEPTH];

  assign ptr_rst_n = rst_ni & prst_ni;
  assign mrst_act  = ~rst_ni;

  // timing choice is only taken while master reset is held
  always_ff @(posedge rclk_i) begin
    if (mrst_act) mode_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
  end

  always_ff @(posedge wclk_i) begin
    if (we) mem[waddr] <= wdata_i;
  end

  dcfifo_rewind_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i(wclk_i), .rst_ni(ptr_rst_n), .wen_ni(wen_ni), .free_gray_s_i(r_free_gray_s),
    .we_o(we), .waddr_o(waddr), .wptr_o(w_ptr), .wgray_o(w_gray), .wfree_o(w_free),
    .full_o(wr_flag_o), .half_o(half_o)
  );

  dcfifo_rewind_sync #(.W(PW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(ptr_rst_n), .d_i(w_gray), .q_o(w_gray_s)
  );

  dcfifo_rewind_sync #(.W(PW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(ptr_rst_n), .d_i(r_free_gray), .q_o(r_free_gray_s)
  );

  dcfifo_rewind_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i(rclk_i), .rst_ni(ptr_rst_n), .mode_i(mode_q), .ren_ni(ren_ni), .mark_i(mark_i),
    .rt_ni(rt_ni), .wgray_s_i(w_gray_s), .mem_q_i(mem[raddr]), .raddr_o(raddr),
    .rdata_o(rdata_o), .rd_flag_o(rd_flag_o), .rptr_o(r_ptr), .rfree_o(r_free),
    .rfree_gray_o(r_free_gray), .mark_ptr_o(mark_ptr), .mark_act_o(mark_act)
  );
endmodule

// File: rtl/dcfifo_rewind_chk.sv
module dcfifo_rewind_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              prst_ni,
  input logic              wen_ni,
  input logic              ren_ni,
  input logic              rt_ni,
  input logic              wr_flag_o,
  input logic              rd_flag_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W:0]   w_ptr,
  input logic [ADDR_W:0]   w_free,
  input logic [ADDR_W:0]   r_ptr,
  input logic [ADDR_W:0]   r_free,
  input logic [ADDR_W:0]   mark_ptr,
  input logic              mark_act,
  input logic              mode_q
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  assert_full_drop_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni || !prst_ni)
    (!wen_ni && wr_flag_o) |=> $stable(w_ptr));

  assert_no_overflow_R11: assert property (@(posedge wclk_i) disable iff (!rst_ni || !prst_ni)
    (PW'(w_ptr - w_free) <= PW'(DEPTH)));

  assert_empty_read_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni || !prst_ni)
    (!mode_q && !ren_ni && rd_flag_o && !(!rt_ni && mark_act)) |=> ($stable(r_ptr) && $stable(rdata_o)));

  assert_rewind_R10: assert property (@(posedge rclk_i) disable iff (!rst_ni || !prst_ni)
    (!rt_ni && mark_act) |=> (r_ptr == $past(mark_ptr)));

  assert_pin_order_R11: assert property (@(posedge rclk_i) disable iff (!rst_ni || !prst_ni)
    mark_act |-> (PW'(r_ptr - mark_ptr) <= PW'(DEPTH) && PW'(mark_ptr - r_free) <= PW'(DEPTH)));

  assert_mode_kept_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(mode_q));
endmodule

bind dcfifo_rewind dcfifo_rewind_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .prst_ni(prst_ni), .wen_ni(wen_ni),
  .ren_ni(ren_ni), .rt_ni(rt_ni), .wr_flag_o(wr_flag_o), .rd_flag_o(rd_flag_o),
  .rdata_o(rdata_o), .w_ptr(w_ptr), .w_free(w_free), .r_ptr(r_ptr), .r_free(r_free),
  .mark_ptr(mark_ptr), .mark_act(mark_act), .mode_q(mode_q)
);

// File: tb/dcfifo_rewind_tb.sv
`timescale 1ns/1ps
module dcfifo_rewind_tb;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0;
  always #2 wclk = ~wclk;    // 250 MHz
  always #3.5 rclk = ~rclk;

  logic rst_n = 0, prst_n = 1, fwft_sel = 0, wen_n = 1, ren_n = 1, mark = 0, rt_n = 1;
  logic [DW-1:0] wdata = '0, rdata;
  logic rd_flag, wr_flag, half;

  dcfifo_rewind #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n), .fwft_sel_i(fwft_sel),
    .wen_ni(wen_n), .wdata_i(wdata), .ren_ni(ren_n), .rdata_o(rdata), .mark_i(mark),
    .rt_ni(rt_n), .rd_flag_o(rd_flag), .wr_flag_o(wr_flag), .half_o(half)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask

  // driver: push to the scoreboard only when the write will be taken
  task automatic put(input logic [DW-1:0] d);
    @(negedge wclk);
    if (!wr_flag) exp_q.push_back(d);
    wen_n = 0; wdata = d;
    @(negedge wclk);
    wen_n = 1;
  endtask

  task automatic put_n(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) put(base + DW'(i));
  endtask

  // monitors: standard pops after the read edge, fall-through compares the presented head
  task automatic take_std(input string req);
    logic [DW-1:0] e;
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
    e = exp_q.pop_front();
    check(req, rdata, e);
  endtask

  task automatic take_fwft(input string req);
    logic [DW-1:0] e;
    @(negedge rclk);
    e = exp_q.pop_front();
    check({req, " presented"}, rd_flag, 0);
    check(req, rdata, e);
    ren_n = 0;
    @(negedge rclk); ren_n = 1;
  endtask

  task automatic master_reset(input logic sel);
    fwft_sel = sel; rst_n = 0;
    rwait(4);
    rst_n = 1;
    exp_q.delete();
    rwait(2);
  endtask

  task automatic partial_reset();
    @(negedge rclk); prst_n = 0;
    rwait(3);
    prst_n = 1;
    exp_q.delete();
    rwait(3);
  endtask

  initial begin
    #800us;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // standard timing
    master_reset(0);
    check("R1 rd_flag", rd_flag, 1);
    check("R1 wr_flag", wr_flag, 0);
    check("R1 half", half, 0);
    fwft_sel = 1;  // R8: must not change the timing now
    put_n(3, 16'h1100);
    rwait(6);
    check("R2 not yet read", rdata, 0);
    check("R2 not empty", rd_flag, 0);
    check("R8 still standard", rdata, 0);
    for (int i = 0; i < 3; i++) take_std("R2 R4 std data");
    rwait(1);
    check("R2 empty after drain", rd_flag, 1);
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
    check("R6 rdata held", rdata, 16'h1102);
    check("R6 still empty", rd_flag, 1);

    // fill, half and full
    put_n(7, 16'h2200);
    check("R7 half below", half, 0);
    put(16'h2207);
    check("R7 half at", half, 1);
    put_n(8, 16'h2208);
    check("R5 full", wr_flag, 1);
    put_n(4, 16'h2F00);
    check("R5 dropped", exp_q.size(), DEPTH);
    rwait(6);
    for (int i = 0; i < DEPTH; i++) take_std("R4 R5 fill order");
    rwait(1);
    check("R5 empty after", rd_flag, 1);

    // partial reset keeps standard timing
    put_n(2, 16'h3300);
    rwait(6);
    partial_reset();
    check("R9 rd_flag", rd_flag, 1);
    check("R9 wr_flag", wr_flag, 0);
    check("R9 half", half, 0);
    put(16'h3355);
    rwait(6);
    check("R9 standard kept", rdata, 0);
    take_std("R9 R2 after partial");

    // fall-through timing
    master_reset(1);
    check("R1 fwft rd_flag", rd_flag, 1);
    check("R1 fwft wr_flag", wr_flag, 0);
    put(16'h4400);
    rwait(4);
    take_fwft("R3 first word");
    put_n(3, 16'h4410);
    rwait(5);
    for (int i = 0; i < 3; i++) take_fwft("R3 R4 fwft data");
    rwait(1);
    check("R3 none presented", rd_flag, 1);

    fwft_sel = 0;
    partial_reset();
    put(16'h5500);
    rwait(5);
    take_fwft("R9 fwft kept");

    // mark and rewind
    put_n(4, 16'h6600);
    rwait(6);
    @(negedge rclk); mark = 1;
    rwait(1);
    take_fwft("R10 before rewind");
    take_fwft("R10 before rewind");
    @(negedge rclk); rt_n = 0;
    @(negedge rclk); rt_n = 1;
    exp_q.push_front(16'h6601);
    exp_q.push_front(16'h6600);
    rwait(3);
    for (int i = 0; i < 4; i++) take_fwft("R10 replay");
    @(negedge rclk); mark = 0;
    rwait(2);

    // pinned storage blocks the writer
    @(negedge rclk); mark = 1;
    rwait(2);
    put_n(DEPTH, 16'h7700);
    check("R11 full", wr_flag, 1);
    rwait(4);
    for (int i = 0; i < 4; i++) take_fwft("R11 read under mark");
    rwait(12);
    check("R11 still full", wr_flag, 1);
    @(negedge rclk); mark = 0;
    rwait(14);
    @(negedge wclk);
    check("R11 released", wr_flag, 0);
    check("R7 half counts held", half, 1);
    for (int i = 0; i < DEPTH - 4; i++) take_fwft("R11 R4 drain");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule